// File: doc/BRIEF.md
# Bus Lock Sequencer for Read-Modify-Write

This block sits between a processor and an external shared bus. The processor has no atomic instruction. The block gives it an indivisible read-modify-write by holding bus ownership across several ordinary accesses. Privileged software writes a dedicated control address with the lock bit set, which arms the sequencer. The next access that targets the external bus window raises a bus request. Once the arbiter grants the bus, the block holds it across the load, the update inside the processor, and the store. Ownership ends only when privileged software writes the control address again with the lock bit clear.

A user-mode access to the control address has no effect on the lock and raises a one-cycle fault pulse. Accesses that fall outside both the bus window and the control address pass by without touching the lock. A hold watchdog keeps the bus from being held forever. After a fixed number of cycles of ownership it forces a release and raises a sticky timeout flag, which stays set until reset.

Top module: `bus_lock_seq`

## Requirements
- R1: After reset, `lock_state` is IDLE (0), and `bus_req`, `bus_hold`, `priv_fault` and `hold_timeout` are all low.
- R2: In IDLE, a kernel-mode write to `CTRL_ADDR` with `cpu_wbit`=1 moves `lock_state` to ARMED (1) on the next cycle, and `bus_req` stays low.
- R3: In ARMED, a valid access whose address has its most significant bit set (the external bus window) moves the state to WAIT_GRANT (2) on the next cycle. `bus_req` is high from that cycle on, and `bus_hold` stays low until the grant.
- R4: In WAIT_GRANT, a high `bus_grant` moves the state to HELD (3) on the next cycle. `bus_hold` is high exactly while the state is HELD, and `bus_req` is high whenever `bus_hold` is high.
- R5: In HELD, bus loads, bus stores, other accesses and further kernel set-writes leave the state in HELD, with `bus_req` and `bus_hold` high.
- R6: A kernel write to `CTRL_ADDR` with `cpu_wbit`=0 does the following, depending on the state:
  - in ARMED, it returns the state to IDLE;
  - in WAIT_GRANT or HELD, it moves the state to RELEASE (4), which lasts one cycle with `bus_req` and `bus_hold` low and is then followed by IDLE;
  - in IDLE, it has no effect.
- R7: A user-mode access (`cpu_kernel`=0) to `CTRL_ADDR`, read or write, leaves the state unchanged. `priv_fault` is high for exactly the following cycle.
- R8: In ARMED, valid accesses whose address MSB is clear and that do not hit `CTRL_ADDR` leave the state in ARMED with `bus_req` low.
- R9: After `HOLD_LIMIT` consecutive cycles in HELD without a clear, the state moves to RELEASE. `bus_hold` is high for exactly `HOLD_LIMIT` cycles, and `hold_timeout` goes high and stays high until reset.
- R10: A clear-write that arrives in the last allowed HELD cycle releases the bus and leaves `hold_timeout` low.
- R11: `bus_grant` is ignored outside WAIT_GRANT. A grant in IDLE or ARMED does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor access strobe, one per cycle |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_kernel | input | 1 | 1 = access issued in kernel mode |
| cpu_addr | input | ADDR_W | Access address; MSB set = external bus window |
| cpu_wbit | input | 1 | Lock bit of the stored word (1 = set lock, 0 = clear) |
| bus_grant | input | 1 | Grant from the bus arbiter |
| bus_req | output | 1 | Bus request, high in WAIT_GRANT and HELD |
| bus_hold | output | 1 | Bus ownership hold, high in HELD |
| priv_fault | output | 1 | One-cycle pulse after a user-mode control access |
| hold_timeout | output | 1 | Sticky flag: watchdog forced a release |
| lock_state | output | 3 | State code: 0 IDLE, 1 ARMED, 2 WAIT_GRANT, 3 HELD, 4 RELEASE |

## Verification
Two events can land in the same cycle: the software clear of the lock and the watchdog expiry in the final HELD cycle. The bench counts cycles from the first cycle it sees `bus_hold` high. It then places the clear-write in cycle `HOLD_LIMIT`-1 and checks that the state moves to RELEASE with `hold_timeout` still low. In a separate run it lets the hold go unattended and checks that the high time of `bus_hold` is exactly `HOLD_LIMIT` and that the timeout flag then latches.

// File: rtl/bls_pkg.sv
// Shared types for the bus lock sequencer.
package bls_pkg;

    // Lock sequencer states; the numeric codes appear on the lock_state port.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARMED   = 3'd1,
        ST_WAIT    = 3'd2,
        ST_HELD    = 3'd3,
        ST_RELEASE = 3'd4
    } lock_state_e;

endpackage

// File: rtl/bls_access_decode.sv
// Classifies each processor access as a bus-window reference, a kernel
// set/clear of the lock control address, or a privilege violation.
// Assumes CTRL_ADDR lies outside the bus window (its MSB is clear).
module bls_access_decode #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic              cpu_kernel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wbit,
    output logic              bus_ref,
    output logic              arm_req,
    output logic              clr_req,
    output logic              priv_fault
);
    localparam int WIN_BIT = ADDR_W - 1;

    logic hit_ctrl;
    logic kern_wr;

    // Decode the current access into lock commands.
    always_comb begin
        hit_ctrl = cpu_valid && (cpu_addr == CTRL_ADDR);
        kern_wr  = hit_ctrl && cpu_write && cpu_kernel;
        arm_req  = kern_wr && cpu_wbit;
        clr_req  = kern_wr && !cpu_wbit;
        bus_ref  = cpu_valid && cpu_addr[WIN_BIT];
    end

    // Register a one-cycle fault pulse for user-mode control accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) priv_fault <= 1'b0;
        else        priv_fault <= hit_ctrl && !cpu_kernel;
    end
endmodule

// File: rtl/bls_hold_watchdog.sv
// Counts cycles of bus ownership and flags expiry on the last allowed one.
// Latches a sticky timeout flag when expiry is not met by a software clear
// in the same cycle. Assumes HOLD_LIMIT >= 2.
module bls_hold_watchdog #(
    parameter int HOLD_LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_held,
    input  logic sw_clr,
    output logic expire,
    output logic hold_timeout
);
    localparam int CNT_W = (HOLD_LIMIT > 2) ? $clog2(HOLD_LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    // Expiry strobe on the final permitted held cycle.
    always_comb expire = in_held && (cnt == LAST);

    // Count held cycles; restart whenever ownership is not held.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (!in_held) cnt <= '0;
        else if (!expire)  cnt <= cnt + 1'b1;
    end

    // Sticky timeout: set when the watchdog itself ends the hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hold_timeout <= 1'b0;
        else if (expire && !sw_clr) hold_timeout <= 1'b1;
    end
endmodule

// File: rtl/bls_lock_fsm.sv
// Arm/request/hold/release state machine. A software clear takes effect
// in any active state; the watchdog can end only the HELD state.
module bls_lock_fsm
    import bls_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm_req,
    input  logic        clr_req,
    input  logic        bus_ref,
    input  logic        bus_grant,
    input  logic        wd_expire,
    output lock_state_e state
);
    lock_state_e nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (arm_req) nxt = ST_ARMED;
            ST_ARMED:   if (clr_req) nxt = ST_IDLE;
                        else if (bus_ref) nxt = ST_WAIT;
            ST_WAIT:    if (clr_req) nxt = ST_RELEASE;
                        else if (bus_grant) nxt = ST_HELD;
            ST_HELD:    if (clr_req || wd_expire) nxt = ST_RELEASE;
            ST_RELEASE: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/bus_lock_seq.sv
// Top of the bus lock sequencer: lets privileged software hold an external
// bus across separate load and store references. Assumes at most one
// processor access per cycle and an external arbiter answering bus_req.
module bus_lock_seq
    import bls_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h10,
    parameter int                HOLD_LIMIT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic              cpu_kernel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wbit,
    input  logic              bus_grant,
    output logic              bus_req,
    output logic              bus_hold,
    output logic              priv_fault,
    output logic              hold_timeout,
    output logic [2:0]        lock_state
);
    logic        bus_ref, arm_req, clr_req, wd_expire;
    lock_state_e state;

    bls_access_decode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_valid  (cpu_valid),
        .cpu_write  (cpu_write),
        .cpu_kernel (cpu_kernel),
        .cpu_addr   (cpu_addr),
        .cpu_wbit   (cpu_wbit),
        .bus_ref    (bus_ref),
        .arm_req    (arm_req),
        .clr_req    (clr_req),
        .priv_fault (priv_fault)
    );

    bls_lock_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_req   (arm_req),
        .clr_req   (clr_req),
        .bus_ref   (bus_ref),
        .bus_grant (bus_grant),
        .wd_expire (wd_expire),
        .state     (state)
    );

    bls_hold_watchdog #(.HOLD_LIMIT(HOLD_LIMIT)) u_wd (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_held      (state == ST_HELD),
        .sw_clr       (clr_req),
        .expire       (wd_expire),
        .hold_timeout (hold_timeout)
    );

    // Bus-side outputs follow the registered state.
    always_comb begin
        bus_req    = (state == ST_WAIT) || (state == ST_HELD);
        bus_hold   = (state == ST_HELD);
        lock_state = state;
    end
endmodule

// File: rtl/bus_lock_seq_chk.sv
// Temporal checks on the bus lock sequencer ports, bound to every instance.
module bus_lock_seq_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_write,
    input logic              cpu_kernel,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wbit,
    input logic              bus_grant,
    input logic              bus_req,
    input logic              bus_hold,
    input logic              priv_fault,
    input logic              hold_timeout,
    input logic [2:0]        lock_state
);
    logic kern_clr, ctrl_hit;
    always_comb begin
        ctrl_hit = cpu_valid && (cpu_addr == CTRL_ADDR);
        kern_clr = ctrl_hit && cpu_write && cpu_kernel && !cpu_wbit;
    end

    a_r4_hold_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |-> bus_req);

    a_r4_hold_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state == 3'd2 && bus_grant && !kern_clr) |=> bus_hold);

    a_r6_release_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state == 3'd4) |=> (lock_state == 3'd0 && !bus_req));

    a_r7_fault_source: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && !cpu_kernel) |=> priv_fault);

    a_r8_armed_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state == 3'd1 && !(cpu_valid && cpu_addr[ADDR_W-1]) && !kern_clr)
        |=> (lock_state == 3'd1));

    a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hold_timeout |=> hold_timeout);

    a_r11_grant_ignored_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state == 3'd0) |=> !bus_hold);
endmodule

bind bus_lock_seq bus_lock_seq_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_valid    (cpu_valid),
    .cpu_write    (cpu_write),
    .cpu_kernel   (cpu_kernel),
    .cpu_addr     (cpu_addr),
    .cpu_wbit     (cpu_wbit),
    .bus_grant    (bus_grant),
    .bus_req      (bus_req),
    .bus_hold     (bus_hold),
    .priv_fault   (priv_fault),
    .hold_timeout (hold_timeout),
    .lock_state   (lock_state)
);

// File: tb/test_bus_lock_seq.sv
// Self-checking bench for the bus lock sequencer.
module test_bus_lock_seq;
    localparam int ADDR_W = 8;
    localparam logic [7:0] CTRL = 8'h10;
    localparam int LIMIT = 256;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_valid = 0, cpu_write = 0, cpu_kernel = 0, cpu_wbit = 0, bus_grant = 0;
    logic [7:0] cpu_addr = '0;
    logic bus_req, bus_hold, priv_fault, hold_timeout;
    logic [2:0] lock_state;
    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bus_lock_seq #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL), .HOLD_LIMIT(LIMIT)) i_bus_lock_seq (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_kernel(cpu_kernel), .cpu_addr(cpu_addr), .cpu_wbit(cpu_wbit),
        .bus_grant(bus_grant), .bus_req(bus_req), .bus_hold(bus_hold),
        .priv_fault(priv_fault), .hold_timeout(hold_timeout), .lock_state(lock_state));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog for a hung run.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            finish_run();
        end
    end

    // Called at a negedge; one access for one cycle, returns at the next negedge.
    task automatic access(input logic [7:0] a, input bit wr, input bit kern, input bit wb);
        cpu_valid = 1; cpu_addr = a; cpu_write = wr; cpu_kernel = kern; cpu_wbit = wb;
        @(negedge clk);
        cpu_valid = 0; cpu_write = 0; cpu_kernel = 0; cpu_wbit = 0; cpu_addr = '0;
    endtask

    task automatic grant_pulse();
        bus_grant = 1;
        @(negedge clk);
        bus_grant = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // From IDLE to the first HELD cycle.
    task automatic go_held();
        access(CTRL, 1, 1, 1);
        access(8'h84, 0, 1, 0);
        grant_pulse();
    endtask

    initial begin
        int n;
        do_reset();
        // R1 reset state
        chk(lock_state == 0 && !bus_req && !bus_hold && !priv_fault && !hold_timeout,
            "R1", lock_state, 0);

        // R11 grant in IDLE ignored
        grant_pulse();
        chk(lock_state == 0, "R11 idle grant", lock_state, 0);
        // R6 clear in IDLE has no effect
        access(CTRL, 1, 1, 0);
        chk(lock_state == 0, "R6 idle clear", lock_state, 0);
        // R7 user set-write in IDLE ignored
        access(CTRL, 1, 0, 1);
        chk(lock_state == 0 && priv_fault, "R7 idle user", lock_state, 0);
        @(negedge clk);

        // R2 arm
        access(CTRL, 1, 1, 1);
        chk(lock_state == 1, "R2 armed", lock_state, 1);
        chk(!bus_req, "R2 no req", bus_req, 0);
        // R11 grant in ARMED ignored
        grant_pulse();
        chk(lock_state == 1, "R11 armed grant", lock_state, 1);

        // R8 sweep of non-bus addresses
        for (int i = 0; i < 16; i++) begin
            for (int w = 0; w < 2; w++) begin
                logic [7:0] a = 8'(i * 8 + 3);
                access(a, w[0], 1, 1);
                chk(lock_state == 1 && !bus_req, "R8 passthrough", lock_state, 1);
            end
        end

        // R7 sweep of user control accesses while armed
        for (int w = 0; w < 2; w++) begin
            for (int b = 0; b < 2; b++) begin
                access(CTRL, w[0], 0, b[0]);
                chk(lock_state == 1, "R7 state kept", lock_state, 1);
                chk(priv_fault == 1, "R7 pulse", priv_fault, 1);
                @(negedge clk);
                chk(priv_fault == 0, "R7 pulse width", priv_fault, 0);
            end
        end

        // R3 bus reference raises request
        access(8'h80, 0, 0, 0);
        chk(lock_state == 2 && bus_req && !bus_hold, "R3 wait grant", lock_state, 2);
        repeat (3) @(negedge clk);
        chk(lock_state == 2 && bus_req, "R3 wait held", lock_state, 2);

        // R4 grant
        grant_pulse();
        chk(lock_state == 3 && bus_hold && bus_req, "R4 held", lock_state, 3);

        // R5 sequence of accesses while held
        access(8'h85, 0, 1, 0);
        chk(lock_state == 3 && bus_hold, "R5 load", lock_state, 3);
        access(8'h22, 1, 1, 1);
        chk(lock_state == 3 && bus_hold, "R5 nonbus", lock_state, 3);
        access(8'h85, 1, 1, 1);
        chk(lock_state == 3 && bus_hold, "R5 store", lock_state, 3);
        access(CTRL, 1, 1, 1);
        chk(lock_state == 3 && bus_req, "R5 set again", lock_state, 3);

        // R6 release from HELD
        access(CTRL, 1, 1, 0);
        chk(lock_state == 4 && !bus_req && !bus_hold, "R6 release", lock_state, 4);
        @(negedge clk);
        chk(lock_state == 0, "R6 back idle", lock_state, 0);

        // R6 clear from ARMED
        access(CTRL, 1, 1, 1);
        access(CTRL, 1, 1, 0);
        chk(lock_state == 0, "R6 armed clear", lock_state, 0);
        // R6 clear from WAIT_GRANT
        access(CTRL, 1, 1, 1);
        access(8'hF0, 1, 1, 0);
        access(CTRL, 1, 1, 0);
        chk(lock_state == 4 && !bus_req, "R6 wait clear", lock_state, 4);
        @(negedge clk);
        chk(lock_state == 0, "R6 wait idle", lock_state, 0);

        // R9 watchdog expiry
        go_held();
        n = 0;
        while (bus_hold && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == LIMIT, "R9 hold length", n, LIMIT);
        chk(lock_state == 4, "R9 forced release", lock_state, 4);
        chk(hold_timeout, "R9 timeout set", hold_timeout, 1);
        access(CTRL, 1, 1, 1);
        access(CTRL, 1, 1, 0);
        chk(hold_timeout, "R9 sticky", hold_timeout, 1);

        // R10 clear in the last allowed held cycle
        do_reset();
        go_held();
        repeat (LIMIT - 1) @(negedge clk);
        chk(lock_state == 3, "R10 still held", lock_state, 3);
        access(CTRL, 1, 1, 0);
        chk(lock_state == 4, "R10 release", lock_state, 4);
        chk(!hold_timeout, "R10 no timeout", hold_timeout, 0);
        // R10 clear one cycle earlier also leaves flag low
        @(negedge clk);
        go_held();
        repeat (LIMIT - 2) @(negedge clk);
        access(CTRL, 1, 1, 0);
        chk(lock_state == 4 && !hold_timeout, "R10 early clear", hold_timeout, 0);

        finish_run();
    end
endmodule